// File: doc/BRIEF.md
# Ping-pong trit link endpoint

This block is one end of a symmetric, full-duplex, point-to-point serial link that carries no clock. Each direction uses two wires, and a symbol ("trit") is sent by toggling one or both of them. Toggling only the low wire carries a 0 bit. Toggling only the high wire carries a 1 bit. Toggling both carries an ACK, which also closes a frame. There is no idle level: only the change matters. The endpoint drives its own wire pair. It receives incoming trits that an external synchroniser has already decoded.

The link paces itself by ping-pong. Every incoming trit is answered by exactly one outgoing trit. That trit is the next bit of the local transmit frame when one is offered, and an ACK otherwise. The endpoint takes transmit bits on a valid/ready interface with a last-bit marker. It returns received frames as a bit stream with an end-of-frame strobe and a length. When this end was the last to send data and has then sent three ACKs in a row, it stops answering ACKs. It then waits until it has data, and resumes with a data trit. An activity timer measures silence since the last incoming trit. When it expires, the link-up flag drops, a partly received frame is thrown away, and an unanswered transmit frame is closed with an ACK. The upstream side must present the bits of one frame back to back. If no bit is waiting when a reply is due, the filler ACK closes the frame.

Top module: `trit_link_endpoint`

## Requirements
- R1: Sending a trit XORs `line_out` with 2'b01 for a 0 bit, 2'b10 for a 1 bit, or 2'b11 for ACK. While `rst` is high, `line_out` is 2'b00 and `link_ok` is 0.
- R2: On the first clock edge after `rst` falls, the endpoint sends one ACK to announce itself.
- R3: An incoming trit is a cycle with `rx_valid` high, with `rx_trit` encoded as 01 for bit 0, 10 for bit 1 and 11 for ACK; code 00 is ignored. On that same edge the endpoint sends exactly one trit. That trit is an ACK if the previously sent bit carried `tx_last`. Otherwise it is the offered bit `tx_bit` when `tx_valid` is high (with `tx_ready` pulsing), and an ACK when nothing is offered.
- R4: Each incoming data trit gives a one-cycle `rxd_valid` pulse, with `rxd_bit` holding the bit, on the edge that takes it in.
- R5: An incoming ACK after one or more data trits pulses `rxd_eof`, with `rxd_len` equal to the bit count. An ACK with no bits pending gives no `rxd_eof`.
- R6: The received-frame length saturates at MAX_LEN (4096 by default). If more bits than that arrive, `rxd_len` reads MAX_LEN and `rxd_ovf` is 1 at that frame's `rxd_eof`. Otherwise `rxd_ovf` is 0.
- R7: Suppose the last data trit on the link was sent by this end, and this end has since sent three ACKs with nothing more to send. Then the next incoming ACK gets no reply.
- R8: An incoming data trit removes that right to stop, so later ACKs keep being answered.
- R9: Once stopped, or after a timeout, a bit offered on `tx_valid` is sent at once as a data trit with no incoming trit. The endpoint never sends an ACK of its own accord, except as stated in R2 and R11.
- R10: `link_ok` goes to 1 on the edge that takes in an incoming trit. It goes to 0 TIMEOUT_CYC edges after the last one.
- R11: On timeout, any received bits not yet closed by an ACK are discarded. An ACK is sent only if the last trit sent was a data bit that the peer has not answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts the link |
| rx_valid | input | 1 | An incoming decoded trit is present this cycle |
| rx_trit | input | 2 | Incoming trit code: 01 bit 0, 10 bit 1, 11 ACK, 00 none |
| tx_valid | input | 1 | A transmit bit is offered |
| tx_bit | input | 1 | Value of the offered transmit bit |
| tx_last | input | 1 | The offered bit is the last one of its frame |
| tx_ready | output | 1 | The offered bit is taken on this edge |
| line_out | output | 2 | Outgoing wire pair; each trit toggles it |
| rxd_valid | output | 1 | Pulse: a received data bit is on rxd_bit |
| rxd_bit | output | 1 | Received data bit |
| rxd_eof | output | 1 | Pulse: a received frame has closed |
| rxd_len | output | 13 | Bit count of the frame closed by rxd_eof |
| rxd_ovf | output | 1 | The frame closed by rxd_eof was longer than MAX_LEN |
| link_ok | output | 1 | An incoming trit has been seen within the timeout window |

## Verification
The hardest situation to reach from the ports is a timeout while a transmit frame is still unanswered. In ordinary ping-pong each data trit is answered in the same cycle, so the frame never stays open. The stimulus first lets the link fall silent until `link_ok` drops, so the endpoint becomes free to start on its own. It then offers a bit that is not the last of its frame, lets it go out spontaneously, and withholds the reply until the next expiry, where the closing ACK must appear. The three-ACK stop window is reached in a similar way. After the endpoint's own frame, the bench answers only with ACKs and counts the replies until the line stays still. In a separate run it breaks the window with a data trit.

// File: rtl/trit_link_pkg.sv
package trit_link_pkg;

    typedef enum logic [1:0] {
        TRIT_NONE = 2'b00,
        TRIT_ZERO = 2'b01,
        TRIT_ONE  = 2'b10,
        TRIT_ACK  = 2'b11
    } trit_e;

    typedef struct packed {
        logic  fire;
        trit_e code;
    } reply_t;

    localparam int ACK_RUN_STOP = 3;

    function automatic trit_e bit_to_trit(input logic b);
        return b ? TRIT_ONE : TRIT_ZERO;
    endfunction

    function automatic logic is_data_trit(input trit_e t);
        return (t == TRIT_ZERO) || (t == TRIT_ONE);
    endfunction

endpackage

// File: rtl/link_timer.sv
module link_timer #(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic expire
);
    localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expire = (cnt_q == LAST) && !kick;

    always_ff @(posedge clk) begin
        if (rst || kick || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import trit_link_pkg::*;
#(
    parameter int MAX_LEN = 4096
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_any,
    input  trit_e                      rx_code,
    input  logic                       flush,
    output logic                       rxd_valid,
    output logic                       rxd_bit,
    output logic                       rxd_eof,
    output logic [$clog2(MAX_LEN+1)-1:0] rxd_len,
    output logic                       rxd_ovf
);
    localparam int LW = $clog2(MAX_LEN + 1);
    localparam logic [LW-1:0] CAP = LW'(MAX_LEN);

    logic [LW-1:0] cnt_q;
    logic          ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            ovf_q     <= 1'b0;
            rxd_valid <= 1'b0;
            rxd_bit   <= 1'b0;
            rxd_eof   <= 1'b0;
            rxd_len   <= '0;
            rxd_ovf   <= 1'b0;
        end else begin
            rxd_valid <= 1'b0;
            rxd_eof   <= 1'b0;
            if (rx_any && is_data_trit(rx_code)) begin
                rxd_valid <= 1'b1;
                rxd_bit   <= (rx_code == TRIT_ONE);
                if (cnt_q == CAP) begin
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (rx_any && rx_code == TRIT_ACK) begin
                if (cnt_q != '0) begin
                    rxd_eof <= 1'b1;
                    rxd_len <= cnt_q;
                    rxd_ovf <= ovf_q;
                end
                cnt_q <= '0;
                ovf_q <= 1'b0;
            end else if (flush) begin
                cnt_q <= '0;
                ovf_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/reply_ctrl.sv
module reply_ctrl
    import trit_link_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rx_any,
    input  trit_e  rx_code,
    input  logic   expire,
    input  logic   tx_valid,
    input  logic   tx_bit,
    input  logic   tx_last,
    output reply_t reply,
    output logic   tx_take,
    output logic   quiet
);
    logic       init_q;
    logic       we_last_q;
    logic       close_q;
    logic       open_q;
    logic       quiet_q;
    logic [1:0] run_q;
    logic       rx_ack;
    logic       rx_data;
    logic       stop_now;

    assign quiet = quiet_q;

    always_comb begin
        rx_ack   = rx_any && (rx_code == TRIT_ACK);
        rx_data  = rx_any && is_data_trit(rx_code);
        stop_now = rx_ack && we_last_q && (run_q == 2'(ACK_RUN_STOP))
                   && !close_q && !tx_valid;
        reply    = '{fire: 1'b0, code: TRIT_NONE};
        tx_take  = 1'b0;
        if (rx_any) begin
            if (!stop_now) begin
                reply.fire = 1'b1;
                if (close_q) begin
                    reply.code = TRIT_ACK;
                end else if (tx_valid) begin
                    reply.code = bit_to_trit(tx_bit);
                    tx_take    = 1'b1;
                end else begin
                    reply.code = TRIT_ACK;
                end
            end
        end else if (quiet_q && tx_valid) begin
            reply.fire = 1'b1;
            reply.code = bit_to_trit(tx_bit);
            tx_take    = 1'b1;
        end else if (expire && (open_q || close_q)) begin
            reply.fire = 1'b1;
            reply.code = TRIT_ACK;
        end else if (init_q) begin
            reply.fire = 1'b1;
            reply.code = TRIT_ACK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q    <= 1'b1;
            we_last_q <= 1'b0;
            close_q   <= 1'b0;
            open_q    <= 1'b0;
            quiet_q   <= 1'b0;
            run_q     <= '0;
        end else begin
            init_q <= 1'b0;
            if (tx_take) begin
                we_last_q <= 1'b1;
                run_q     <= '0;
                close_q   <= tx_last;
                open_q    <= !tx_last;
            end else begin
                if (reply.fire && reply.code == TRIT_ACK) begin
                    if (run_q != 2'(ACK_RUN_STOP)) begin
                        run_q <= run_q + 1'b1;
                    end
                    close_q <= 1'b0;
                    open_q  <= 1'b0;
                end
                if (rx_data) begin
                    we_last_q <= 1'b0;
                end
            end
            if (stop_now) begin
                quiet_q <= 1'b1;
            end else if (tx_take || rx_any) begin
                quiet_q <= 1'b0;
            end else if (expire) begin
                quiet_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trit_link_endpoint.sv
module trit_link_endpoint
    import trit_link_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int MAX_LEN     = 4096
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rx_valid,
    input  logic [1:0]                   rx_trit,
    input  logic                         tx_valid,
    input  logic                         tx_bit,
    input  logic                         tx_last,
    output logic                         tx_ready,
    output logic [1:0]                   line_out,
    output logic                         rxd_valid,
    output logic                         rxd_bit,
    output logic                         rxd_eof,
    output logic [$clog2(MAX_LEN+1)-1:0] rxd_len,
    output logic                         rxd_ovf,
    output logic                         link_ok
);
    trit_e  rx_code;
    logic   rx_any;
    logic   tmr_expire;
    logic   ctl_quiet;
    reply_t reply;
    logic   tx_take;
    logic [1:0] line_q;

    assign rx_code  = trit_e'(rx_trit);
    assign rx_any   = rx_valid && (rx_code != TRIT_NONE);
    assign tx_ready = tx_take;
    assign line_out = line_q;

    link_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .kick   (rx_any),
        .expire (tmr_expire)
    );

    rx_deframer #(.MAX_LEN(MAX_LEN)) u_deframe (
        .clk       (clk),
        .rst       (rst),
        .rx_any    (rx_any),
        .rx_code   (rx_code),
        .flush     (tmr_expire),
        .rxd_valid (rxd_valid),
        .rxd_bit   (rxd_bit),
        .rxd_eof   (rxd_eof),
        .rxd_len   (rxd_len),
        .rxd_ovf   (rxd_ovf)
    );

    reply_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rx_any   (rx_any),
        .rx_code  (rx_code),
        .expire   (tmr_expire),
        .tx_valid (tx_valid),
        .tx_bit   (tx_bit),
        .tx_last  (tx_last),
        .reply    (reply),
        .tx_take  (tx_take),
        .quiet    (ctl_quiet)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 2'b00;
        end else if (reply.fire) begin
            line_q <= line_q ^ reply.code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_ok <= 1'b0;
        end else if (rx_any) begin
            link_ok <= 1'b1;
        end else if (tmr_expire) begin
            link_ok <= 1'b0;
        end
    end
endmodule

// File: rtl/trit_link_checker.sv
module trit_link_checker #(
    parameter int MAX_LEN = 4096
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         rx_valid,
    input logic [1:0]                   rx_trit,
    input logic [1:0]                   line_out,
    input logic                         link_ok,
    input logic                         rxd_eof,
    input logic [$clog2(MAX_LEN+1)-1:0] rxd_len,
    input logic                         expire,
    input logic                         quiet
);
    localparam int LW = $clog2(MAX_LEN + 1);

    logic rx_any;
    logic rx_data;
    assign rx_any  = rx_valid && (rx_trit != 2'b00);
    assign rx_data = rx_valid && (rx_trit == 2'b01 || rx_trit == 2'b10);

    assert_data_answered_R3: assert property (@(posedge clk) disable iff (rst)
        rx_data |=> (line_out != $past(line_out)));

    assert_eof_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        rxd_eof |-> (rxd_len != '0));

    assert_len_cap_R6: assert property (@(posedge clk) disable iff (rst)
        rxd_len <= LW'(MAX_LEN));

    assert_link_up_R10: assert property (@(posedge clk) disable iff (rst)
        rx_any |=> link_ok);

    assert_link_down_R10: assert property (@(posedge clk) disable iff (rst)
        (expire && !rx_any) |=> !link_ok);

    assert_resume_data_R9: assert property (@(posedge clk) disable iff (rst)
        (quiet && !rx_any && !expire) |=> ($countones(line_out ^ $past(line_out)) <= 1));
endmodule

bind trit_link_endpoint trit_link_checker #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_trit  (rx_trit),
    .line_out (line_out),
    .link_ok  (link_ok),
    .rxd_eof  (rxd_eof),
    .rxd_len  (rxd_len),
    .expire   (tmr_expire),
    .quiet    (ctl_quiet)
);

// File: tb/sim_trit_link_endpoint.sv
module sim_trit_link_endpoint;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 64;
    localparam int MAXL = 4096;
    localparam logic [1:0] D0 = 2'b01, D1 = 2'b10, AK = 2'b11, NO = 2'b00;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic [1:0] rx_trit = 2'b00;
    logic tx_valid = 1'b0, tx_bit = 1'b0, tx_last = 1'b0;
    logic tx_ready;
    logic [1:0] line_out;
    logic rxd_valid, rxd_bit, rxd_eof, rxd_ovf, link_ok;
    logic [12:0] rxd_len;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [1:0] prev_line = 2'b00;
    logic [1:0] last_delta = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    trit_link_endpoint #(.TIMEOUT_CYC(TMO), .MAX_LEN(MAXL)) u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_trit(rx_trit),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_last(tx_last), .tx_ready(tx_ready),
        .line_out(line_out), .rxd_valid(rxd_valid), .rxd_bit(rxd_bit),
        .rxd_eof(rxd_eof), .rxd_len(rxd_len), .rxd_ovf(rxd_ovf), .link_ok(link_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic note_line;
        last_delta = line_out ^ prev_line;
        prev_line  = line_out;
    endtask

    task automatic step_rx(input logic [1:0] t);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_trit  = t;
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
        rx_trit  = 2'b00;
        note_line();
    endtask

    task automatic idle_cycle;
        @(posedge clk);
        #1;
        note_line();
    endtask

    task automatic expect_reply(input logic [1:0] exp, input string req);
        chk(last_delta == exp, req, int'(last_delta), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(line_out == 2'b00, "R1 reset line", int'(line_out), 0);
        chk(link_ok == 1'b0, "R1 reset link_ok", int'(link_ok), 0);
        @(negedge clk);
        rst = 1'b0;
        idle_cycle();
        expect_reply(AK, "R2 init ack");
        chk(link_ok == 1'b0, "R10 no link before rx", int'(link_ok), 0);

        // R3: transmit sweep, every pattern of length 1..6, peer answers ACKs
        for (int len = 1; len <= 6; len++) begin
            for (int pat = 0; pat < (1 << len); pat++) begin
                for (int i = 0; i < len; i++) begin
                    tx_valid = 1'b1;
                    tx_bit   = pat[i];
                    tx_last  = (i == len - 1);
                    step_rx(AK);
                    expect_reply(pat[i] ? D1 : D0, "R3 tx bit");
                end
                tx_valid = 1'b0;
                tx_last  = 1'b0;
                tx_bit   = 1'b0;
                step_rx(AK);
                expect_reply(AK, "R3 frame close");
            end
        end
        chk(link_ok == 1'b1, "R10 link up", int'(link_ok), 1);

        // R7: two more ACKs, then the next incoming ACK is not answered
        step_rx(AK); expect_reply(AK, "R7 ack 2");
        step_rx(AK); expect_reply(AK, "R7 ack 3");
        step_rx(AK); expect_reply(NO, "R7 stop");
        step_rx(AK); expect_reply(NO, "R7 stay stopped");
        idle_cycle(); expect_reply(NO, "R9 no own ack");
        idle_cycle(); expect_reply(NO, "R9 no own ack");

        // R9: resume with a data trit and no incoming trit
        tx_valid = 1'b1; tx_bit = 1'b0; tx_last = 1'b1;
        idle_cycle();
        tx_valid = 1'b0; tx_last = 1'b0;
        expect_reply(D0, "R9 resume data");
        step_rx(AK); expect_reply(AK, "R3 close after resume");
        step_rx(AK); expect_reply(AK, "R7 window ack 2");
        step_rx(AK); expect_reply(AK, "R7 window ack 3");

        // R8: data inside the window cancels the stop
        step_rx(D0);
        expect_reply(AK, "R8 data answered");
        chk(rxd_valid && rxd_bit == 1'b0, "R4 bit in window", int'(rxd_bit), 0);
        step_rx(AK);
        expect_reply(AK, "R8 ack answered");
        chk(rxd_eof && rxd_len == 13'd1, "R5 one-bit frame", int'(rxd_len), 1);
        for (int k = 0; k < 4; k++) begin
            step_rx(AK);
            expect_reply(AK, "R8 keeps answering");
        end

        // R4/R5: receive sweep
        for (int len = 1; len <= 6; len++) begin
            for (int pat = 0; pat < (1 << len); pat++) begin
                for (int i = 0; i < len; i++) begin
                    step_rx(pat[i] ? D1 : D0);
                    chk(rxd_valid && !rxd_eof && rxd_bit == pat[i], "R4 rx bit",
                        int'(rxd_bit), pat[i]);
                    expect_reply(AK, "R3 ack to data");
                end
                step_rx(AK);
                chk(rxd_eof && rxd_len == 13'(len) && !rxd_ovf, "R5 rx eof len",
                    int'(rxd_len), len);
            end
        end
        step_rx(AK);
        chk(!rxd_eof, "R5 empty ack no eof", int'(rxd_eof), 0);
        step_rx(NO);
        expect_reply(NO, "R3 code 00 ignored");
        chk(!rxd_valid && !rxd_eof, "R3 code 00 no output", int'(rxd_valid), 0);

        // R3/R4: full duplex, 4-bit frames both ways
        for (int pa = 0; pa < 16; pa++) begin
            for (int i = 0; i < 4; i++) begin
                tx_valid = 1'b1; tx_bit = pa[3 - i]; tx_last = (i == 3);
                step_rx(pa[i] ? D1 : D0);
                expect_reply(pa[3 - i] ? D1 : D0, "R3 duplex tx");
                chk(rxd_valid && rxd_bit == pa[i], "R4 duplex rx", int'(rxd_bit), pa[i]);
            end
            tx_valid = 1'b0; tx_last = 1'b0;
            step_rx(AK);
            expect_reply(AK, "R3 duplex close");
            chk(rxd_eof && rxd_len == 13'd4, "R5 duplex len", int'(rxd_len), 4);
        end
        step_rx(D1); expect_reply(AK, "R3 ack after duplex");
        step_rx(AK); expect_reply(AK, "R3 ack after duplex");

        // R10/R11: timeout drops link and discards partial bits
        step_rx(D0); step_rx(D1);
        for (int k = 0; k < TMO - 1; k++) idle_cycle();
        chk(link_ok == 1'b1, "R10 before timeout", int'(link_ok), 1);
        idle_cycle();
        chk(link_ok == 1'b0, "R10 timeout", int'(link_ok), 0);
        expect_reply(NO, "R11 no ack without open frame");
        step_rx(AK);
        chk(!rxd_eof, "R11 partial discarded", int'(rxd_eof), 0);
        chk(link_ok == 1'b1, "R10 link back", int'(link_ok), 1);
        expect_reply(AK, "R3 ack after timeout");
        step_rx(D1); step_rx(AK);
        chk(rxd_eof && rxd_len == 13'd1, "R11 clean frame", int'(rxd_len), 1);

        // R11: unanswered open frame closed by ACK at timeout
        for (int k = 0; k < TMO; k++) idle_cycle();
        chk(link_ok == 1'b0, "R10 timeout again", int'(link_ok), 0);
        tx_valid = 1'b1; tx_bit = 1'b1; tx_last = 1'b0;
        idle_cycle();
        tx_valid = 1'b0; tx_bit = 1'b0;
        expect_reply(D1, "R9 resume after timeout");
        begin
            int waited = 0;
            logic [1:0] seen = 2'b00;
            while (seen == 2'b00 && waited < TMO + 2) begin
                idle_cycle();
                seen = last_delta;
                waited++;
            end
            chk(seen == AK, "R11 close open frame", int'(seen), int'(AK));
        end
        idle_cycle(); expect_reply(NO, "R11 single ack");

        // R6: exact MAX_LEN frame, then oversized frame
        for (int k = 0; k < MAXL; k++) step_rx(D0);
        step_rx(AK);
        chk(rxd_eof && rxd_len == 13'(MAXL) && !rxd_ovf, "R6 exact max", int'(rxd_ovf), 0);
        for (int k = 0; k < MAXL + 3; k++) step_rx(D1);
        step_rx(AK);
        chk(rxd_eof && rxd_len == 13'(MAXL), "R6 saturated len", int'(rxd_len), MAXL);
        chk(rxd_ovf == 1'b1, "R6 overflow flag", int'(rxd_ovf), 1);
        step_rx(D0); step_rx(AK);
        chk(rxd_eof && rxd_len == 13'd1 && !rxd_ovf, "R6 flag cleared", int'(rxd_ovf), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule